// File: doc/BRIEF.md
# Lane-Split Unsigned Magnitude Comparator

This block compares two 16-bit operands as packed unsigned lanes. The word is divided into four 4-bit granules. A cut vector, which can change at run time, chooses where lanes end. Each lane is compared on its own bits only, and six relation vectors come out at once: equal, not equal, less, less-or-equal, greater and greater-or-equal.

Every relation vector has one bit per granule. A lane reports its result on the bit of its lowest granule. All other bits are held at zero. The cut encoding is the one the partitioned adder uses, so both blocks can share the same lane configuration. The path from input to output is purely combinational.

Top module: `psimd_cmp`

## Requirements
- R1: Each lane is compared as an unsigned number made of only its own bits. A result bit is 1 exactly when its relation holds for that lane.
- R2: With cut vector 3'b000 there is one 16-bit lane, and only bit 0 of each result vector can be 1.
- R3: With cut vector 3'b010 there are two 8-bit lanes. The low byte reports on bit 0 and the high byte reports on bit 2.
- R4: With cut vector 3'b111 there are four 4-bit lanes. Nibble k reports on bit k, for k from 0 to 3.
- R5: A result bit whose granule is not the lowest granule of a lane is 0 in all six vectors.
- R6: For each lane, ne is the inverse of eq, le equals lt OR eq, and ge equals gt OR eq.
- R7: For each lane, exactly one of lt, eq and gt is 1.
- R8: Cut bit k set to 1 ends a lane between granule k and granule k+1. Any mix of cuts is valid, which gives lanes of unequal width (for example 3'b001 makes a 4-bit lane and a 12-bit lane).
- R9: A lane's result depends only on its own bits. Differences in other lanes have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | Left operand |
| b_i | input | 16 | Right operand |
| cut_i | input | 3 | Lane cuts; bit k splits granule k from granule k+1 |
| eq_o | output | 4 | Lane equal, reported at the lane's lowest granule |
| ne_o | output | 4 | Lane not equal |
| lt_o | output | 4 | Lane a less than b |
| le_o | output | 4 | Lane a less than or equal to b |
| gt_o | output | 4 | Lane a greater than b |
| ge_o | output | 4 | Lane a greater than or equal to b |

## Verification
The block holds no state, so a wrong cut decode or a broken significance chain shows at the ports as soon as the inputs settle. Such faults appear as a result on the wrong bit, a stray 1 on a bit that is not a lane start, or a lane whose outcome follows the bits of its neighbour. Operand pairs that are equal in one lane and differ in the lane next to it expose a chain that was not cut. Boundary pairs built from 0x0000 and 0xFFFF expose ordering that is not unsigned.

// File: rtl/psimd_cmp_pkg.sv
package psimd_cmp_pkg;

  typedef struct packed {
    logic eq;
    logic gt;
  } rel_t;

  // Relation of two granules, zero-extended to a common width.
  function automatic rel_t rel_of(input logic [31:0] x, input logic [31:0] y);
    rel_t r;
    r.eq = (x == y);
    r.gt = (x > y);
    return r;
  endfunction

  // Join a more significant relation with a less significant one.
  function automatic rel_t rel_join(input rel_t hi, input rel_t lo);
    rel_t r;
    r.eq = hi.eq & lo.eq;
    r.gt = hi.gt | (hi.eq & lo.gt);
    return r;
  endfunction

endpackage

// File: rtl/psimd_cmp_gran.sv
module psimd_cmp_gran
  import psimd_cmp_pkg::*;
#(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  output rel_t          rel_o
);
  assign rel_o = rel_of(32'(a_i), 32'(b_i));
endmodule

// File: rtl/psimd_cmp_chain.sv
module psimd_cmp_chain
  import psimd_cmp_pkg::*;
#(
  parameter int unsigned NG = 4
) (
  input  rel_t [NG-1:0] gran_i,
  input  logic [NG-2:0] cut_i,
  output rel_t [NG-1:0] acc_o
);
  // acc_o[i] covers granule i up to the top of its lane
  for (genvar i = 0; i < NG; i++) begin : g_link
    if (i == NG - 1) begin : g_top
      assign acc_o[i] = gran_i[i];
    end else begin : g_mid
      assign acc_o[i] = cut_i[i] ? gran_i[i] : rel_join(acc_o[i+1], gran_i[i]);
    end
  end
endmodule

// File: rtl/psimd_cmp_place.sv
module psimd_cmp_place
  import psimd_cmp_pkg::*;
#(
  parameter int unsigned NG = 4
) (
  input  rel_t [NG-1:0] acc_i,
  input  logic [NG-2:0] cut_i,
  output logic [NG-1:0] start_o,
  output logic [NG-1:0] eq_o,
  output logic [NG-1:0] ne_o,
  output logic [NG-1:0] lt_o,
  output logic [NG-1:0] le_o,
  output logic [NG-1:0] gt_o,
  output logic [NG-1:0] ge_o
);
  logic [NG-1:0] eq_raw, gt_raw;

  assign start_o = {cut_i, 1'b1};

  for (genvar i = 0; i < NG; i++) begin : g_bit
    assign eq_raw[i] = acc_i[i].eq;
    assign gt_raw[i] = acc_i[i].gt;
  end

  assign eq_o = start_o & eq_raw;
  assign gt_o = start_o & gt_raw;
  assign ne_o = start_o & ~eq_raw;
  assign lt_o = start_o & ~eq_raw & ~gt_raw;
  assign le_o = start_o & ~gt_raw;
  assign ge_o = start_o & (gt_raw | eq_raw);
endmodule

// File: rtl/psimd_cmp.sv
module psimd_cmp
  import psimd_cmp_pkg::*;
#(
  parameter int unsigned GW = 4,
  parameter int unsigned NG = 4,
  localparam int unsigned W = GW * NG
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [NG-2:0] cut_i,
  output logic [NG-1:0] eq_o,
  output logic [NG-1:0] ne_o,
  output logic [NG-1:0] lt_o,
  output logic [NG-1:0] le_o,
  output logic [NG-1:0] gt_o,
  output logic [NG-1:0] ge_o
);
  rel_t [NG-1:0] gran_rel;
  rel_t [NG-1:0] lane_rel;
  logic [NG-1:0] lane_start;

  for (genvar g = 0; g < NG; g++) begin : g_gran
    psimd_cmp_gran #(.GW(GW)) u_gran (
      .a_i   (a_i[g*GW +: GW]),
      .b_i   (b_i[g*GW +: GW]),
      .rel_o (gran_rel[g])
    );
  end

  psimd_cmp_chain #(.NG(NG)) u_chain (
    .gran_i (gran_rel),
    .cut_i  (cut_i),
    .acc_o  (lane_rel)
  );

  psimd_cmp_place #(.NG(NG)) u_place (
    .acc_i   (lane_rel),
    .cut_i   (cut_i),
    .start_o (lane_start),
    .eq_o    (eq_o),
    .ne_o    (ne_o),
    .lt_o    (lt_o),
    .le_o    (le_o),
    .gt_o    (gt_o),
    .ge_o    (ge_o)
  );
endmodule

// File: rtl/psimd_cmp_chk.sv
module psimd_cmp_chk #(
  parameter int unsigned NG = 4,
  parameter int unsigned W  = 16
) (
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic [NG-2:0] cut_i,
  input logic [NG-1:0] lane_start,
  input logic [NG-1:0] eq_o,
  input logic [NG-1:0] ne_o,
  input logic [NG-1:0] lt_o,
  input logic [NG-1:0] le_o,
  input logic [NG-1:0] gt_o,
  input logic [NG-1:0] ge_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, cut_i})) begin
      p_start_low_r2: assert (lane_start[0] == 1'b1);
      p_lane_count_r8: assert ($countones(lane_start) == $countones(cut_i) + 1);
      p_off_start_zero_r5: assert (((eq_o | ne_o | lt_o | le_o | gt_o | ge_o) & ~lane_start) == '0);
      p_ne_inverse_r6: assert (ne_o == (lane_start & ~eq_o));
      p_le_join_r6: assert (le_o == (lt_o | eq_o));
      p_ge_join_r6: assert (ge_o == (gt_o | eq_o));
      for (int i = 0; i < NG; i++) begin
        if (lane_start[i]) begin
          p_one_outcome_r7: assert ($countones({lt_o[i], eq_o[i], gt_o[i]}) == 1);
        end
      end
    end
  end
endmodule

bind psimd_cmp psimd_cmp_chk #(.NG(NG), .W(W)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .cut_i      (cut_i),
  .lane_start (lane_start),
  .eq_o       (eq_o),
  .ne_o       (ne_o),
  .lt_o       (lt_o),
  .le_o       (le_o),
  .gt_o       (gt_o),
  .ge_o       (ge_o)
);

// File: tb/psimd_cmp_tb_top.sv
module psimd_cmp_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [15:0] a, b;
  logic [2:0]  cut;
  logic [3:0]  eq, ne, lt, le, gt, ge;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  psimd_cmp dut_i (
    .a_i(a), .b_i(b), .cut_i(cut),
    .eq_o(eq), .ne_o(ne), .lt_o(lt), .le_o(le), .gt_o(gt), .ge_o(ge)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Per-lane reference: extract each lane arithmetically.
  task automatic model(input logic [15:0] av, input logic [15:0] bv, input logic [2:0] c,
                       output logic [3:0] m_eq, output logic [3:0] m_ne, output logic [3:0] m_lt,
                       output logic [3:0] m_le, output logic [3:0] m_gt, output logic [3:0] m_ge,
                       output logic [3:0] m_st);
    int lo;
    longint unsigned msk, x, y;
    lo = 0;
    m_eq = 0; m_ne = 0; m_lt = 0; m_le = 0; m_gt = 0; m_ge = 0; m_st = 0;
    for (int g = 0; g < 4; g++) begin
      if (g == 3 || c[g]) begin
        msk = (64'd1 << (4 * (g - lo + 1))) - 1;
        x = (64'(av) >> (4 * lo)) & msk;
        y = (64'(bv) >> (4 * lo)) & msk;
        m_st[lo] = 1'b1;
        m_eq[lo] = (x == y);
        m_ne[lo] = (x != y);
        m_lt[lo] = (x < y);
        m_le[lo] = (x <= y);
        m_gt[lo] = (x > y);
        m_ge[lo] = (x >= y);
        lo = g + 1;
      end
    end
  endtask

  task automatic chk(input string what, input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s a=%h b=%h cut=%b: got %b expected %b", tag, what, a, b, cut, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] av, input logic [15:0] bv, input logic [2:0] c, input string tag);
    logic [3:0] e_eq, e_ne, e_lt, e_le, e_gt, e_ge, st;
    @(posedge clk);
    #2;
    a = av; b = bv; cut = c;
    @(negedge clk);
    model(av, bv, c, e_eq, e_ne, e_lt, e_le, e_gt, e_ge, st);
    chk("eq", tag, eq, e_eq);
    chk("ne", tag, ne, e_ne);
    chk("lt", tag, lt, e_lt);
    chk("le", tag, le, e_le);
    chk("gt", tag, gt, e_gt);
    chk("ge", tag, ge, e_ge);
    chk("off-start bits (R5)", "R5", (eq | ne | lt | le | gt | ge) & ~st, 4'b0000);
    chk("ne vs eq (R6)", "R6", ne, st & ~eq);
    chk("le join (R6)", "R6", le, lt | eq);
    chk("ge join (R6)", "R6", ge, gt | eq);
    chk("single outcome (R7)", "R7", (lt & eq) | (lt & gt) | (eq & gt) | (st & ~(lt | eq | gt)), 4'b0000);
  endtask

  logic [15:0] pa [10] = '{16'h0000, 16'h0000, 16'hFFFF, 16'h1234, 16'h8000, 16'hABCD, 16'h01FF, 16'hF00F, 16'h7FFF, 16'h0F0F};
  logic [15:0] pb [10] = '{16'h0000, 16'hFFFF, 16'h0000, 16'h1235, 16'h7FFF, 16'hABCD, 16'h0200, 16'h0FF0, 16'h8000, 16'hF0F0};

  task automatic t_reset();
    @(negedge clk);
    chk("eq after reset (R2)", "R2", eq, 4'b0001);
    chk("le after reset (R2)", "R2", le, 4'b0001);
    chk("ge after reset (R2)", "R2", ge, 4'b0001);
    chk("lt after reset (R2)", "R2", lt, 4'b0000);
  endtask

  task automatic t_single();
    for (int i = 0; i < 10; i++) apply(pa[i], pb[i], 3'b000, "R1/R2");
  endtask

  task automatic t_bytes();
    for (int i = 0; i < 10; i++) apply(pa[i], pb[i], 3'b010, "R3");
  endtask

  task automatic t_nibbles();
    for (int i = 0; i < 10; i++) apply(pa[i], pb[i], 3'b111, "R4");
  endtask

  task automatic t_mixed();
    for (int c = 1; c < 7; c++)
      for (int i = 0; i < 10; i++) apply(pa[i], pb[i], 3'(c), "R8");
  endtask

  task automatic t_isolate();
    // high byte a>b, low byte a<b: each lane must follow only its own bits
    apply(16'h2000, 16'h10FF, 3'b010, "R9");
    chk("low byte lt (R9)", "R9", lt, 4'b0001);
    chk("high byte gt (R9)", "R9", gt, 4'b0100);
    apply(16'h5A5A, 16'h5A5B, 3'b111, "R9");
    chk("nibble 0 only lt (R9)", "R9", lt, 4'b0001);
    chk("upper nibbles eq (R9)", "R9", eq, 4'b1110);
  endtask

  initial begin
    a = 16'h0000; b = 16'h0000; cut = 3'b000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_bytes();
    t_nibbles();
    t_mixed();
    t_isolate();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule